// File: doc/BRIEF.md
# LED Brightness PWM Controller

This block turns a brightness request into the drive for one LED pin. A request runs from zero up to a configured maximum. The two end points are served as fixed pin levels. Any value strictly between them is produced by a PWM channel inside the block. For that channel the block picks a clock divide ratio and then computes the period and the compare point from the input clock rate and the refresh rate. Both rates are plain configuration inputs.

A request is offered as a value with a one-cycle valid strobe. While the block recomputes its settings it holds the channel stopped and raises busy. A shared sequential divider forms the two quotients it needs, so a PWM change takes a few dozen cycles. Requests that arrive during that time are not lost. Only the most recent one is kept, and it is applied once the current one has finished. If the clock is too slow to give the required count resolution, the block flags an error and releases the pin.

Top module: `led_pwm_ctrl`

## Requirements
- R1: After reset the pin is driven (led_oe_o=1) and low, and busy_o and err_o are both 0.
- R2: A brightness of 0 makes the pin a static low. A brightness equal to or above the maximum makes it a static high. In both cases led_oe_o=1 and err_o=0.
- R3: The minimum count rate is the maximum brightness times the refresh rate. A refresh rate of 0 is replaced by 100.
- R4: The divide ratio is the largest of 1, 4, 16 and 64 for which the clock rate is at least the ratio times the minimum rate. The PWM counter advances once every ratio clock cycles.
- R5: If the clock rate is below the minimum rate, err_o=1 and led_oe_o=0 and the PWM stays stopped. This lasts until a later request is applied, which clears err_o.
- R6: The period count is floor(clock rate / (ratio × refresh)). The counter clears after reaching period−1, so one PWM cycle lasts period × ratio clock cycles.
- R7: The compare value is floor((max − brightness) × period / max). The pin is low from the counter clear until the count reaches the compare value, then high until the period ends. The high time is therefore (period − compare) × ratio clock cycles.
- R8: While new PWM settings are being computed, the channel is stopped and the pin is low. It restarts from count zero only after both the period and the compare value are loaded.
- R9: busy_o rises in the cycle after brt_valid_i and stays high until the settings are applied. Of the requests that arrive while busy, only the last is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_rate_i | input | RATE_W | Input clock rate, in clock cycles per time unit |
| refresh_i | input | REF_W | PWM refresh rate; 0 selects 100 |
| max_brt_i | input | BRT_W | Maximum brightness |
| brt_i | input | BRT_W | Requested brightness |
| brt_valid_i | input | 1 | Strobe that accepts brt_i |
| led_o | output | 1 | LED pin level |
| led_oe_o | output | 1 | Pin drive enable |
| busy_o | output | 1 | Request pending or settings being computed |
| err_o | output | 1 | Clock too slow for the requested resolution |

## Verification
The hardest conditions to reach from the ports are the recompute window and the pending request. The window is short, and the pin stays low there even if the PWM was high just before. The bench first starts a PWM output that is high for most of its cycle, then issues a new request and samples the pin on every cycle while busy is high. It also sends two more requests while the divider is still running, and measures the resulting waveform to show that only the last one took effect. The divide-ratio boundaries are reached with clock rates that sit exactly at a multiple of the minimum rate.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam int unsigned NUM_RATIO = 4;

  typedef enum logic [1:0] {PIN_OFF, PIN_LOW, PIN_HIGH, PIN_PWM} pin_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PER, ST_CMP} calc_st_e;
endpackage

// File: rtl/led_pwm_div.sv
module led_pwm_div #(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        den_q  <= divisor_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign done_o = done_q;

  // R6/R7 quotients come from a bounded shift sequence
  a_r6_div_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
  a_r7_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/led_pwm_prescale.sv
module led_pwm_prescale import led_pwm_pkg::*; #(
  parameter int unsigned RATE_W = 32,
  parameter int unsigned BRT_W  = 8,
  parameter int unsigned REF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [BRT_W-1:0]  max_i,
  input  logic [REF_W-1:0]  ref_i,
  output logic              ok_o,
  output logic [1:0]        shift_o
);
  localparam int unsigned MIN_W = BRT_W + REF_W;
  localparam int unsigned CMP_W = RATE_W + MIN_W + 2 * NUM_RATIO;

  logic [MIN_W-1:0]     min_rate;
  logic [NUM_RATIO-1:0] fit;

  assign min_rate = MIN_W'(max_i) * MIN_W'(ref_i);

  for (genvar k = 0; k < NUM_RATIO; k++) begin : g_ratio
    assign fit[k] = CMP_W'(rate_i) >= (CMP_W'(min_rate) << (2 * k));
    if (k > 0) begin : g_chk
      a_r4_fit_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fit[k] |-> fit[k-1]);
    end
  end

  always_comb begin
    shift_o = '0;
    for (int k = 1; k < NUM_RATIO; k++)
      if (fit[k]) shift_o = 2'(k);
    ok_o = fit[0];
  end
endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       shift_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  logic [5:0]       pre_q, pre_last;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign pre_last = (6'd1 << {shift_i, 1'b0}) - 6'd1;
  assign tick     = pre_q == pre_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? 6'd0 : pre_q + 6'd1;
      if (tick) cnt_q <= (cnt_q == period_i - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // low until compare match, high for the rest of the period
  assign pwm_o = run_i && (cnt_q >= cmp_i);

  a_r6_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < period_i);
  a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && cnt_q == period_i - CNT_W'(1)) |=> cnt_q == '0);
  a_r7_cmp_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cmp_i < period_i);
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl import led_pwm_pkg::*; #(
  parameter int unsigned BRT_W   = 8,
  parameter int unsigned RATE_W  = 32,
  parameter int unsigned REF_W   = 16,
  parameter int unsigned DEF_REF = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] clk_rate_i,
  input  logic [REF_W-1:0]  refresh_i,
  input  logic [BRT_W-1:0]  max_brt_i,
  input  logic [BRT_W-1:0]  brt_i,
  input  logic              brt_valid_i,
  output logic              led_o,
  output logic              led_oe_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam int unsigned DIV_W = RATE_W + BRT_W;

  calc_st_e          st_q;
  pin_mode_e         mode_q;
  logic              err_q, run_q, pend_q;
  logic [BRT_W-1:0]  pend_brt_q, cur_brt_q, cur_max_q;
  logic [1:0]        shift_q, sel_shift;
  logic [RATE_W-1:0] per_q, cmp_q;
  logic [REF_W-1:0]  ref_eff;
  logic              sel_ok, take, take_pwm, pwm;
  logic              div_start, div_done;
  logic [DIV_W-1:0]  div_a, div_b, div_q;
  logic              unused_hi;

  assign ref_eff = (refresh_i == '0) ? REF_W'(DEF_REF) : refresh_i;

  led_pwm_prescale #(.RATE_W(RATE_W), .BRT_W(BRT_W), .REF_W(REF_W)) u_pre (
    .clk_i, .rst_ni, .rate_i(clk_rate_i), .max_i(max_brt_i), .ref_i(ref_eff),
    .ok_o(sel_ok), .shift_o(sel_shift));

  assign take     = (st_q == ST_IDLE) && pend_q;
  assign take_pwm = take && (pend_brt_q != '0) && (pend_brt_q < max_brt_i) && sel_ok;

  always_comb begin
    if (st_q == ST_PER) begin
      div_start = div_done;
      div_a     = DIV_W'(cur_max_q - cur_brt_q) * DIV_W'(div_q[RATE_W-1:0]);
      div_b     = DIV_W'(cur_max_q);
    end else begin
      div_start = take_pwm;
      div_a     = DIV_W'(clk_rate_i >> {sel_shift, 1'b0});
      div_b     = DIV_W'(ref_eff);
    end
  end

  led_pwm_div #(.W(DIV_W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .dividend_i(div_a), .divisor_i(div_b),
    .quot_o(div_q), .done_o(div_done));

  assign unused_hi = ^div_q[DIV_W-1:RATE_W];

  // newest request overwrites any pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_brt_q <= '0;
    end else if (brt_valid_i) begin
      pend_q     <= 1'b1;
      pend_brt_q <= brt_i;
    end else if (take) begin
      pend_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mode_q <= PIN_LOW; err_q <= 1'b0; run_q <= 1'b0;
      cur_brt_q <= '0; cur_max_q <= '0; shift_q <= '0; per_q <= '0; cmp_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (take) begin
          cur_brt_q <= pend_brt_q;
          cur_max_q <= max_brt_i;
          run_q     <= 1'b0;
          if (pend_brt_q == '0) begin
            mode_q <= PIN_LOW;  err_q <= 1'b0;
          end else if (pend_brt_q >= max_brt_i) begin
            mode_q <= PIN_HIGH; err_q <= 1'b0;
          end else if (!sel_ok) begin
            mode_q <= PIN_OFF;  err_q <= 1'b1;
          end else begin
            mode_q  <= PIN_PWM; err_q <= 1'b0;
            shift_q <= sel_shift;
            st_q    <= ST_PER;
          end
        end
        ST_PER: if (div_done) begin
          per_q <= div_q[RATE_W-1:0];
          st_q  <= ST_CMP;
        end
        ST_CMP: if (div_done) begin
          cmp_q <= div_q[RATE_W-1:0];
          run_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  led_pwm_gen #(.CNT_W(RATE_W)) u_gen (
    .clk_i, .rst_ni, .run_i(run_q), .shift_i(shift_q), .period_i(per_q),
    .cmp_i(cmp_q), .pwm_o(pwm));

  assign led_oe_o = mode_q != PIN_OFF;
  assign led_o    = (mode_q == PIN_HIGH) || ((mode_q == PIN_PWM) && pwm);
  assign busy_o   = (st_q != ST_IDLE) || pend_q;
  assign err_o    = err_q;

  a_r8_stopped_while_calc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !run_q);
  a_r2_static_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PIN_PWM) |-> !run_q);
  a_r5_err_releases_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !led_oe_o);
  a_r9_valid_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brt_valid_i |=> busy_o);
endmodule

// File: tb/tb_led_pwm_ctrl.sv
module tb_led_pwm_ctrl;
  localparam int unsigned K_LOW = 0, K_HIGH = 1, K_PWM = 2, K_ERR = 3;

  typedef struct packed {
    logic [31:0] rate;
    logic [15:0] refr;
    logic [7:0]  maxb;
    logic [7:0]  brt;
    logic [1:0]  kind;
    logic [15:0] per_c;
    logic [15:0] hi_c;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd1000,   16'd10, 8'd10, 8'd3,   2'd2, 16'd100,  16'd32},   // R4 R6 R7 ratio 4
    '{32'd500,    16'd0,  8'd4,  8'd2,   2'd2, 16'd5,    16'd3},    // R3 default refresh
    '{32'd100000, 16'd50, 8'd20, 8'd15,  2'd2, 16'd1984, 16'd1536}, // R4 ratio 64
    '{32'd1600,   16'd10, 8'd10, 8'd5,   2'd2, 16'd160,  16'd80},   // R4 boundary ratio 16
    '{32'd1000,   16'd10, 8'd10, 8'd1,   2'd2, 16'd100,  16'd12},   // R7 near off
    '{32'd1000,   16'd10, 8'd10, 8'd0,   2'd0, 16'd0,    16'd0},    // R2 low
    '{32'd1000,   16'd10, 8'd10, 8'd10,  2'd1, 16'd0,    16'd0},    // R2 high
    '{32'd1000,   16'd10, 8'd10, 8'd200, 2'd1, 16'd0,    16'd0},    // R2 above max
    '{32'd50,     16'd10, 8'd10, 8'd5,   2'd3, 16'd0,    16'd0},    // R5 too slow
    '{32'd1000,   16'd10, 8'd10, 8'd9,   2'd2, 16'd100,  16'd92}    // R5 err cleared, R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rate = '0;
  logic [15:0] refr = '0;
  logic [7:0]  maxb = '0, brt = '0;
  logic        valid = 1'b0;
  logic        led, led_oe, busy, err;
  int          errors = 0, checks = 0, cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  led_pwm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_rate_i(rate), .refresh_i(refr),
    .max_brt_i(maxb), .brt_i(brt), .brt_valid_i(valid),
    .led_o(led), .led_oe_o(led_oe), .busy_o(busy), .err_o(err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic [7:0] b);
    @(negedge clk);
    brt = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int per);
    int lo = 0;
    hi = 0;
    for (int i = 0; i < 5000 && led; i++) @(negedge clk);
    for (int i = 0; i < 5000 && !led; i++) @(negedge clk);
    for (int i = 0; i < 5000 && led; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 5000 && !led; i++) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic static_level(input logic exp, input string tag);
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (led !== exp) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1'b1;
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int hi, per, bad, busy_len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(led_oe === 1'b1, "R1 oe", int'(led_oe), 1);
    check(led === 1'b0, "R1 led", int'(led), 0);
    check(busy === 1'b0 && err === 1'b0, "R1 busy/err", int'({busy, err}), 0);

    for (int v = 0; v < NV; v++) begin
      rate = VECS[v].rate; refr = VECS[v].refr; maxb = VECS[v].maxb;
      request(VECS[v].brt);
      wait_idle();
      @(negedge clk);
      case (int'(VECS[v].kind))
        K_LOW: begin
          check(led_oe && !err, "R2 low drive", int'({led_oe, err}), 2);
          static_level(1'b0, "R2 static low");
        end
        K_HIGH: begin
          check(led_oe && !err, "R2 high drive", int'({led_oe, err}), 2);
          static_level(1'b1, "R2 static high");
        end
        K_ERR: begin
          check(err === 1'b1 && led_oe === 1'b0, "R5 err undriven", int'({led_oe, err}), 1);
          static_level(1'b0, "R5 pwm stopped");
        end
        default: begin
          check(led_oe && !err, "R5 pwm drive, err clear", int'({led_oe, err}), 2);
          measure(hi, per);
          check(per == int'(VECS[v].per_c), "R6 period", per, int'(VECS[v].per_c));
          check(hi == int'(VECS[v].hi_c), "R7 high time", hi, int'(VECS[v].hi_c));
        end
      endcase
    end

    // R8: from a mostly-high PWM, recompute must hold the pin low
    rate = 1000; refr = 10; maxb = 10;
    @(negedge clk);
    brt = 8'd5; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(busy === 1'b1, "R9 busy after valid", int'(busy), 1);
    @(negedge clk);
    bad = 0; busy_len = 0;
    for (int i = 0; i < 5000 && busy; i++) begin
      if (led !== 1'b0) bad++;
      busy_len++;
      @(negedge clk);
    end
    check(bad == 0, "R8 low during recompute", bad, 0);
    check(busy_len > 10, "R9 busy held while computing", busy_len, 11);
    measure(hi, per);
    check(hi == 52 && per == 100, "R8 restart brt5", hi, 52);

    // R9: requests during busy, only the last one applies
    request(8'd3);
    repeat (5) @(negedge clk);
    request(8'd7);
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R9 still busy", int'(busy), 1);
    request(8'd1);
    wait_idle();
    measure(hi, per);
    check(hi == 12, "R9 latest kept high", hi, 12);
    check(per == 100, "R9 latest kept period", per, 100);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule